// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the byte-addressed program counter of a small processor whose registers are 16 bits wide. It drives a word address (the PC with its two low bits dropped) to an external instruction ROM and passes the returned 32-bit word on to the decoder. Each cycle it chooses the next PC from three cases. A control transfer requested by the decoder through a 2-bit branch-kind code takes precedence. Otherwise the PC moves forward one word. If the fetched word is zero, the PC stays where it is, because an all-zero word marks the end of the program.

For a conditional branch, the decision is made from the 16-bit ALU result the pipeline supplies. A greater-or-equal branch looks at the sign of a subtraction. A not-equal branch checks whether an XOR of the operands is nonzero. A taken branch adds the signed word offset, scaled to bytes, to the PC. A jump-and-link loads the scaled jump target and offers the PC minus four on a register write port aimed at register 31. Any taken transfer raises a redirect pulse in the same cycle, so that the caller can squash younger work.

Top module: `pc_redirect_unit`

## Requirements
- R1: While reset (`rst_n` low, asynchronous) is asserted, the PC is zero, `rom_addr` is zero and `prog_end` is low, whatever `rom_data` holds.
- R2: `rom_addr` equals the PC divided by four. `instr_out` equals `rom_data` in the same cycle.
- R3: With no redirect and a nonzero fetched word, the PC grows by 4 at the next clock edge.
- R4: A fetched word of all zeros drives `prog_end` high in the same cycle. With no redirect, the PC holds its value over the next edge.
- R5: Branch kind 2 (greater-or-equal) is taken exactly when bit 15 of `alu_res` is 0. When taken, the next PC is PC + 4 × signed `br_off`. When not taken, the sequential rule applies.
- R6: Branch kind 3 (not-equal) is taken exactly when `alu_res` is nonzero. When taken, it makes the same offset update as R5.
- R7: Branch kind 1 (jump-and-link) is always taken. In that cycle `link_we` is high, `link_idx` is 31 and `link_data` is PC − 4. The next PC is `jmp_tgt` × 4.
- R8: Branch kind 0 never raises `redirect_o`. `link_we` is high only for kind 1. `redirect_o` is high in exactly the cycles where a transfer is taken.
- R9: A taken transfer sets the next PC even when the fetched word is zero, and in place of the +4 step.
- R10: All PC arithmetic (offset add, target scaling, PC − 4) wraps modulo 2^16 for the default PC width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| br_kind | input | 2 | 0 none, 1 jump-and-link, 2 greater-or-equal, 3 not-equal |
| alu_res | input | 16 | ALU result used for the branch decision |
| br_off | input | 16 | Signed branch offset in words |
| jmp_tgt | input | 26 | Jump target in words |
| rom_data | input | 32 | Word returned by the instruction ROM |
| rom_addr | output | 14 | Word address to the instruction ROM |
| instr_out | output | 32 | Fetched instruction |
| redirect_o | output | 1 | A transfer is taken this cycle |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index (31) |
| link_data | output | 16 | Return value written to the link register |
| prog_end | output | 1 | Fetched word is the zero sentinel |

## Verification
The hardest case to reach is a zero sentinel word arriving in the same cycle as a taken transfer, because the halt rule and the redirect rule then compete for the next PC. The stimulus forces this directly with a not-equal branch over a zero word, then leaves it to recur at random, since zero words are injected at a fixed rate. The sign boundary of the greater-or-equal test (0x7FFF against 0x8000) and a link taken from PC zero are also directed. The link case shows the wrap to 0xFFFC.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;
  typedef enum logic [1:0] {
    BR_NONE = 2'd0,
    BR_LINK = 2'd1,
    BR_GE   = 2'd2,
    BR_NE   = 2'd3
  } br_kind_e;

  localparam logic [4:0] LINK_REG = 5'd31;
endpackage

// File: rtl/pc_branch_decide.sv
module pc_branch_decide
  import pc_unit_pkg::*;
#(
  parameter int ALU_W = 16
) (
  input  br_kind_e           kind,
  input  logic [ALU_W-1:0]   alu_res,
  output logic               taken,
  output logic               is_link
);
  // Sign of the subtraction decides greater-or-equal; any set bit decides not-equal.
  function automatic logic ge_hit(input logic [ALU_W-1:0] v);
    return ~v[ALU_W-1];
  endfunction

  function automatic logic ne_hit(input logic [ALU_W-1:0] v);
    return |v;
  endfunction

  always_comb begin
    taken   = 1'b0;
    is_link = 1'b0;
    unique case (kind)
      BR_NONE: taken = 1'b0;
      BR_LINK: begin
        taken   = 1'b1;
        is_link = 1'b1;
      end
      BR_GE:   taken = ge_hit(alu_res);
      BR_NE:   taken = ne_hit(alu_res);
      default: taken = 1'b0;
    endcase
  end
endmodule

// File: rtl/pc_target_calc.sv
module pc_target_calc
  import pc_unit_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int OFF_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [PC_W-1:0]  pc,
  input  logic             is_link,
  input  logic [OFF_W-1:0] off,
  input  logic [TGT_W-1:0] tgt,
  output logic [PC_W-1:0]  redirect_pc,
  output logic [PC_W-1:0]  seq_pc,
  output logic [PC_W-1:0]  link_val
);
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  // Word offset to byte offset, sign extended then cut to PC width.
  function automatic logic [PC_W-1:0] off_bytes(input logic [OFF_W-1:0] o);
    return PC_W'({{PC_W{o[OFF_W-1]}}, o, 2'b00});
  endfunction

  // Word target to byte address, cut to PC width.
  function automatic logic [PC_W-1:0] tgt_bytes(input logic [TGT_W-1:0] t);
    return PC_W'({{PC_W{1'b0}}, t, 2'b00});
  endfunction

  always_comb begin
    seq_pc      = pc + STEP;
    link_val    = pc - STEP;
    redirect_pc = is_link ? tgt_bytes(tgt) : (pc + off_bytes(off));
  end
endmodule

// File: rtl/pc_state_reg.sv
module pc_state_reg #(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_redirect,
  input  logic            word_live,
  input  logic [PC_W-1:0] redirect_pc,
  input  logic [PC_W-1:0] seq_pc,
  output logic [PC_W-1:0] pc_q
);
  logic [PC_W-1:0] pc_d;

  // Redirect first, then sequential step, else hold on the sentinel.
  always_comb begin
    if (take_redirect)  pc_d = redirect_pc;
    else if (word_live) pc_d = seq_pc;
    else                pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/pc_redirect_unit.sv
module pc_redirect_unit
  import pc_unit_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int ALU_W  = 16,
  parameter int OFF_W  = 16,
  parameter int TGT_W  = 26,
  parameter int WORD_W = 32,
  localparam int RA_W  = PC_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        br_kind,
  input  logic [ALU_W-1:0]  alu_res,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [TGT_W-1:0]  jmp_tgt,
  input  logic [WORD_W-1:0] rom_data,
  output logic [RA_W-1:0]   rom_addr,
  output logic [WORD_W-1:0] instr_out,
  output logic              redirect_o,
  output logic              link_we,
  output logic [4:0]        link_idx,
  output logic [PC_W-1:0]   link_data,
  output logic              prog_end
);
  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] redirect_pc;
  logic [PC_W-1:0] seq_pc;
  logic            take_redirect;
  logic            is_link;
  logic            word_live;
  br_kind_e        kind;

  assign kind      = br_kind_e'(br_kind);
  assign word_live = |rom_data;

  pc_branch_decide #(.ALU_W(ALU_W)) u_decide (
    .kind    (kind),
    .alu_res (alu_res),
    .taken   (take_redirect),
    .is_link (is_link)
  );

  pc_target_calc #(.PC_W(PC_W), .OFF_W(OFF_W), .TGT_W(TGT_W)) u_calc (
    .pc          (pc_q),
    .is_link     (is_link),
    .off         (br_off),
    .tgt         (jmp_tgt),
    .redirect_pc (redirect_pc),
    .seq_pc      (seq_pc),
    .link_val    (link_data)
  );

  pc_state_reg #(.PC_W(PC_W)) u_pc (
    .clk           (clk),
    .rst_n         (rst_n),
    .take_redirect (take_redirect),
    .word_live     (word_live),
    .redirect_pc   (redirect_pc),
    .seq_pc        (seq_pc),
    .pc_q          (pc_q)
  );

  assign rom_addr   = pc_q[PC_W-1:2];
  assign instr_out  = rom_data;
  assign redirect_o = take_redirect;
  assign link_we    = is_link;
  assign link_idx   = LINK_REG;
  assign prog_end   = rst_n & ~word_live;
endmodule

// File: rtl/pc_redirect_unit_chk.sv
module pc_redirect_unit_chk #(
  parameter int PC_W   = 16,
  parameter int ALU_W  = 16,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        br_kind,
  input logic [ALU_W-1:0]  alu_res,
  input logic [PC_W-3:0]   tgt_lo,
  input logic [WORD_W-1:0] rom_data,
  input logic [PC_W-1:0]   pc_q,
  input logic              redirect_o,
  input logic              link_we,
  input logic              prog_end
);
  a_r3_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_o && rom_data != '0) |=> pc_q == PC_W'($past(pc_q) + PC_W'(4)));

  a_r4_halt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!redirect_o && rom_data == '0) |=> $stable(pc_q));

  a_r4_end_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    prog_end |-> rom_data == '0);

  a_r5_ge_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd2 && !alu_res[ALU_W-1]) |-> redirect_o);

  a_r6_ne_zero_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (br_kind == 2'd3 && alu_res == '0) |-> !redirect_o);

  a_r7_link_load: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |=> (pc_q[PC_W-1:2] == $past(tgt_lo) && pc_q[1:0] == 2'b00));

  a_r8_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    br_kind == 2'd0 |-> (!redirect_o && !link_we));

  a_r8_link_redirects: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> redirect_o);
endmodule

bind pc_redirect_unit pc_redirect_unit_chk #(
  .PC_W(PC_W), .ALU_W(ALU_W), .WORD_W(WORD_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .br_kind    (br_kind),
  .alu_res    (alu_res),
  .tgt_lo     (jmp_tgt[PC_W-3:0]),
  .rom_data   (rom_data),
  .pc_q       (pc_q),
  .redirect_o (redirect_o),
  .link_we    (link_we),
  .prog_end   (prog_end)
);

// File: tb/tb_pc_redirect_unit.sv
`timescale 1ns/1ps
module tb_pc_redirect_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  br_kind = '0;
  logic [15:0] alu_res = '0;
  logic [15:0] br_off = '0;
  logic [25:0] jmp_tgt = '0;
  logic [31:0] rom_data = '0;
  logic [13:0] rom_addr;
  logic [31:0] instr_out;
  logic        redirect_o;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [15:0] link_data;
  logic        prog_end;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_pc = '0;
  string pc_tag = "R1";

  always #5 clk = ~clk;

  pc_redirect_unit dut (
    .clk(clk), .rst_n(rst_n), .br_kind(br_kind), .alu_res(alu_res),
    .br_off(br_off), .jmp_tgt(jmp_tgt), .rom_data(rom_data),
    .rom_addr(rom_addr), .instr_out(instr_out), .redirect_o(redirect_o),
    .link_we(link_we), .link_idx(link_idx), .link_data(link_data),
    .prog_end(prog_end)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference decision written from the requirement text.
  function automatic bit ref_taken(input logic [1:0] k, input logic [15:0] a);
    case (k)
      2'd1:    return 1'b1;
      2'd2:    return $signed(a) >= 0;
      2'd3:    return a != 16'd0;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] ref_next(input logic [15:0] pc, input logic [1:0] k,
      input logic [15:0] a, input logic [15:0] o, input logic [25:0] t, input logic [31:0] w);
    int s;
    if (ref_taken(k, a)) begin
      if (k == 2'd1) s = int'(t) * 4;
      else           s = int'(pc) + 4 * int'($signed(o));
    end else if (w != 32'd0) s = int'(pc) + 4;
    else                     s = int'(pc);
    return s[15:0];
  endfunction

  task automatic step(input logic [1:0] k, input logic [15:0] a, input logic [15:0] o,
      input logic [25:0] t, input logic [31:0] w, input string force_tag);
    bit tk;
    string ktag;
    @(negedge clk);
    br_kind = k; alu_res = a; br_off = o; jmp_tgt = t; rom_data = w;
    #1;
    chk(rom_addr == exp_pc[15:2], pc_tag, 32'(rom_addr), 32'(exp_pc[15:2]));
    chk(instr_out == w, "R2", instr_out, w);
    chk(prog_end == (w == 32'd0), "R4", 32'(prog_end), 32'(w == 32'd0));
    tk = ref_taken(k, a);
    ktag = (k == 2'd0) ? "R8" : (k == 2'd1) ? "R7" : (k == 2'd2) ? "R5" : "R6";
    chk(redirect_o == tk, ktag, 32'(redirect_o), 32'(tk));
    chk(link_we == (k == 2'd1), "R8", 32'(link_we), 32'(k == 2'd1));
    if (k == 2'd1) begin
      chk(link_idx == 5'd31, "R7", 32'(link_idx), 32'd31);
      chk(link_data == 16'(exp_pc - 16'd4), "R7", 32'(link_data), 32'(16'(exp_pc - 16'd4)));
    end
    if (force_tag != "")       pc_tag = force_tag;
    else if (tk && w == 32'd0) pc_tag = "R9";
    else if (tk)               pc_tag = ktag;
    else if (w != 32'd0)       pc_tag = "R3";
    else                       pc_tag = "R4";
    exp_pc = ref_next(exp_pc, k, a, o, t, w);
  endtask

  initial begin
    void'($urandom(32'h1F2E3D4C));
    rom_data = 32'd0;
    repeat (2) @(negedge clk);
    #1;
    chk(rom_addr == 14'd0, "R1", 32'(rom_addr), 32'd0);
    chk(prog_end == 1'b0, "R1", 32'(prog_end), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    exp_pc = 16'd0;
    pc_tag = "R1";
    // jump-and-link from PC 0: link value wraps
    step(2'd1, 16'h0000, 16'h0000, 26'h3FF_FFF5, 32'h1234_5678, "R10");
    step(2'd0, 16'h0000, 16'h0000, 26'd0, 32'hAAAA_0001, "");
    step(2'd0, 16'h0000, 16'h0000, 26'd0, 32'h0000_0000, "");
    step(2'd0, 16'h0000, 16'h0000, 26'd0, 32'h0000_0000, "");
    // not-equal taken over the sentinel
    step(2'd3, 16'h0001, 16'hFFFE, 26'd0, 32'h0000_0000, "");
    step(2'd2, 16'h8000, 16'h0010, 26'd0, 32'h0000_0F00, "R5");
    step(2'd2, 16'h7FFF, 16'h0010, 26'd0, 32'h0000_0F00, "");
    step(2'd2, 16'h0000, 16'hFFF0, 26'd0, 32'h0000_0F00, "");
    step(2'd3, 16'h0000, 16'h0020, 26'd0, 32'h0000_0F00, "R6");
    step(2'd3, 16'h8000, 16'h7FFF, 26'd0, 32'h0000_0F00, "R10");
    step(2'd1, 16'h5555, 16'h0000, 26'h000_0040, 32'h0000_0000, "");
    for (int i = 0; i < 600; i++) begin
      logic [1:0]  k;
      logic [15:0] a;
      logic [31:0] w;
      int sel;
      k = 2'($urandom % 4);
      sel = int'($urandom % 6);
      a = (sel == 0) ? 16'h0000 : (sel == 1) ? 16'h8000 : 16'($urandom);
      w = (($urandom % 8) == 0) ? 32'd0 : ($urandom | 32'd1);
      step(k, a, 16'($urandom), 26'($urandom), w, "");
    end
    @(negedge clk);
    #1;
    chk(rom_addr == exp_pc[15:2], pc_tag, 32'(rom_addr), 32'(exp_pc[15:2]));
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule